// File: doc/BRIEF.md
# Virtual Address Region and Protection Checker

This block validates one memory access per clock against a paged, region-split virtual address space with four privilege levels. The caller presents a 32-bit virtual address, whether the access is a read or a write, the privilege mode of the requester, the length limit of each of the three usable regions, and the page table entry that covers the address. The caller has already fetched that entry. The block works out which region the address falls in. It checks the page number against that region's limit and checks the entry's protection code against the mode and access type. One cycle later it returns either a physical address with a valid strobe or exactly one fault code.

The two top address bits select the region. The next 21 bits are the virtual page number, and the low 9 bits are the byte offset within a 512-byte page. Regions 0 and 2 grow upward from page zero. Region 1 grows downward from the top of its range. Region 3 is reserved. A physical address is issued only when no fault applies. The block does not walk page tables, cache translations or deliver exceptions.

Top module: `avr_xlate_check`

## Requirements
- R1: Address bits 31:30 select the region, bits 29:9 are the page number and bits 8:0 the offset. Any request with bits 31:30 equal to 3 raises only flt_rsv_o in the next cycle.
- R2: In regions 0 and 2, a page number greater than or equal to that region's limit (rgn0_len_i, rgn2_len_i) raises flt_len_o.
- R3: In region 1, a page number strictly less than rgn1_len_i raises flt_len_o. Page numbers at or above the limit pass the length check.
- R4: Modes are encoded 0 kernel, 1 executive, 2 supervisor, 3 user, with lower values more privileged. A read is allowed when mode_i is less than or equal to prot_i[1:0]. Otherwise flt_acc_o is raised.
- R5: A write is allowed when mode_i is less than or equal to prot_i[3:2]. Otherwise flt_acc_o is raised.
- R6: A protection code whose write level prot_i[3:2] is numerically greater than its read level prot_i[1:0] is invalid. It raises flt_acc_o for every mode and access type.
- R7: Exactly one result is reported per request. The reserved-region fault outranks the length fault, and the length fault outranks the access fault.
- R8: With no fault, pa_valid_o is high one cycle after the request and pa_o equals {pfn_i, offset}. When pa_valid_o is low, pa_o is zero.
- R9: A cycle with req_i low gives all outputs zero in the following cycle.
- R10: While rst_ni is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request present this cycle |
| va_i | input | 32 | Virtual address |
| wr_i | input | 1 | 1 = write, 0 = read |
| mode_i | input | 2 | Requester privilege (0 kernel .. 3 user) |
| rgn0_len_i | input | 22 | Page-count limit of region 0 |
| rgn1_len_i | input | 22 | Lowest legal page of region 1 |
| rgn2_len_i | input | 22 | Page-count limit of region 2 |
| prot_i | input | 4 | Protection code: [3:2] write level, [1:0] read level |
| pfn_i | input | 21 | Page frame number from the entry |
| pa_o | output | 30 | Physical address |
| pa_valid_o | output | 1 | Physical address valid |
| flt_len_o | output | 1 | Length violation |
| flt_acc_o | output | 1 | Access violation |
| flt_rsv_o | output | 1 | Reserved region access |

## Verification
The bench works on the limit boundaries in each region: page equal to the limit and page one below it. A design that checks the downward region like the upward ones, or that uses the wrong comparison operator, fails those cases. It checks reads and writes from each mode against codes with split read and write levels. A design that swaps the two fields or inverts the privilege order lets a user write to kernel pages. It also checks the invalid codes, where the write level is looser than the read level. Requests that break both the length and protection rules show whether priority was kept. Idle cycles and faulting cycles show whether a stale or partial physical address leaks out.

// File: rtl/avr_pkg.sv
package avr_pkg;
  localparam int VA_W  = 32;
  localparam int OFF_W = 9;
  localparam int RGN_W = 2;
  localparam int VPN_W = VA_W - RGN_W - OFF_W;
  localparam int LEN_W = VPN_W + 1;
  localparam int N_RGN = 3;
  localparam int PROT_W = 4;

  typedef enum logic [1:0] {
    MODE_KERNEL = 2'd0,
    MODE_EXEC   = 2'd1,
    MODE_SUPER  = 2'd2,
    MODE_USER   = 2'd3
  } mode_e;

  typedef struct packed {
    logic [RGN_W-1:0] rgn;
    logic [VPN_W-1:0] vpn;
    logic [OFF_W-1:0] off;
  } va_t;
endpackage

// File: rtl/avr_va_split.sv
module avr_va_split
  import avr_pkg::*;
(
  input  logic [VA_W-1:0] va_i,
  output va_t             va_o,
  output logic            rsv_o
);
  assign va_o  = va_t'(va_i);
  assign rsv_o = (va_o.rgn == RGN_W'(N_RGN));
endmodule

// File: rtl/avr_len_check.sv
module avr_len_check
  import avr_pkg::*;
#(
  parameter logic [N_RGN-1:0] DOWN_MASK = 3'b010
) (
  input  logic [RGN_W-1:0]            rgn_i,
  input  logic [VPN_W-1:0]            vpn_i,
  input  logic [N_RGN-1:0][LEN_W-1:0] len_i,
  output logic                        flt_o
);
  logic [N_RGN-1:0] rgn_flt;
  logic [LEN_W-1:0] vpn_ext;

  assign vpn_ext = {1'b0, vpn_i};

  for (genvar g = 0; g < N_RGN; g++) begin : g_rgn
    if (DOWN_MASK[g]) begin : g_down
      assign rgn_flt[g] = vpn_ext < len_i[g];
    end else begin : g_up
      assign rgn_flt[g] = vpn_ext >= len_i[g];
    end
  end

  always_comb begin
    flt_o = 1'b0;
    for (int i = 0; i < N_RGN; i++) begin
      if (rgn_i == RGN_W'(i)) flt_o = rgn_flt[i];
    end
  end
endmodule

// File: rtl/avr_prot_decode.sv
module avr_prot_decode
  import avr_pkg::*;
(
  input  logic [PROT_W-1:0] prot_i,
  input  mode_e             mode_i,
  input  logic              wr_i,
  output logic              flt_o
);
  logic [1:0] rd_lvl, wr_lvl, need_lvl;
  logic       bad_code;

  assign rd_lvl   = prot_i[1:0];
  assign wr_lvl   = prot_i[3:2];
  // write must never be looser than read
  assign bad_code = wr_lvl > rd_lvl;
  assign need_lvl = wr_i ? wr_lvl : rd_lvl;
  assign flt_o    = bad_code | (mode_i > need_lvl);
endmodule

// File: rtl/avr_xlate_check.sv
module avr_xlate_check
  import avr_pkg::*;
#(
  parameter int PFN_W = 21,
  localparam int PA_W = PFN_W + OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [VA_W-1:0]   va_i,
  input  logic              wr_i,
  input  logic [1:0]        mode_i,
  input  logic [LEN_W-1:0]  rgn0_len_i,
  input  logic [LEN_W-1:0]  rgn1_len_i,
  input  logic [LEN_W-1:0]  rgn2_len_i,
  input  logic [PROT_W-1:0] prot_i,
  input  logic [PFN_W-1:0]  pfn_i,
  output logic [PA_W-1:0]   pa_o,
  output logic              pa_valid_o,
  output logic              flt_len_o,
  output logic              flt_acc_o,
  output logic              flt_rsv_o
);
  va_t                        va_s;
  logic                       rsv_hit, len_hit, acc_hit;
  logic [N_RGN-1:0][LEN_W-1:0] len_tbl;
  logic                       rsv_d, len_d, acc_d, ok_d;

  assign len_tbl = {rgn2_len_i, rgn1_len_i, rgn0_len_i};

  avr_va_split u_split (
    .va_i  (va_i),
    .va_o  (va_s),
    .rsv_o (rsv_hit)
  );

  avr_len_check u_len (
    .rgn_i (va_s.rgn),
    .vpn_i (va_s.vpn),
    .len_i (len_tbl),
    .flt_o (len_hit)
  );

  avr_prot_decode u_prot (
    .prot_i (prot_i),
    .mode_i (mode_e'(mode_i)),
    .wr_i   (wr_i),
    .flt_o  (acc_hit)
  );

  // priority: reserved > length > access
  assign rsv_d = req_i & rsv_hit;
  assign len_d = req_i & ~rsv_hit & len_hit;
  assign acc_d = req_i & ~rsv_hit & ~len_hit & acc_hit;
  assign ok_d  = req_i & ~rsv_hit & ~len_hit & ~acc_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pa_o       <= '0;
      pa_valid_o <= 1'b0;
      flt_len_o  <= 1'b0;
      flt_acc_o  <= 1'b0;
      flt_rsv_o  <= 1'b0;
    end else begin
      pa_o       <= ok_d ? {pfn_i, va_s.off} : '0;
      pa_valid_o <= ok_d;
      flt_len_o  <= len_d;
      flt_acc_o  <= acc_d;
      flt_rsv_o  <= rsv_d;
    end
  end
endmodule

// File: rtl/avr_xlate_check_sva.sv
module avr_xlate_check_sva
  import avr_pkg::*;
#(
  parameter int PFN_W = 21,
  localparam int PA_W = PFN_W + OFF_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic [VA_W-1:0]   va_i,
  input logic              wr_i,
  input logic [1:0]        mode_i,
  input logic [LEN_W-1:0]  rgn0_len_i,
  input logic [PROT_W-1:0] prot_i,
  input logic [PFN_W-1:0]  pfn_i,
  input logic [PA_W-1:0]   pa_o,
  input logic              pa_valid_o,
  input logic              flt_len_o,
  input logic              flt_acc_o,
  input logic              flt_rsv_o
);
  p_one_result_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> $countones({pa_valid_o, flt_len_o, flt_acc_o, flt_rsv_o}) == 1);

  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> ({pa_valid_o, flt_len_o, flt_acc_o, flt_rsv_o} == 4'b0) && (pa_o == '0));

  p_reserved_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && va_i[31:30] == 2'b11) |=> flt_rsv_o);

  p_pa_form_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i ##1 pa_valid_o) |-> pa_o == {$past(pfn_i), $past(va_i[OFF_W-1:0])});

  p_pa_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pa_valid_o |-> pa_o == '0);

  p_user_wr_kernel_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && va_i[31:30] == 2'b00 && {1'b0, va_i[29:9]} < rgn0_len_i &&
     wr_i && mode_i == 2'd3 && prot_i == 4'h0) |=> flt_acc_o);

  p_bad_code_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && va_i[31:30] == 2'b00 && {1'b0, va_i[29:9]} < rgn0_len_i &&
     prot_i[3:2] > prot_i[1:0]) |=> flt_acc_o);

  p_rgn0_len_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && va_i[31:30] == 2'b00 && {1'b0, va_i[29:9]} >= rgn0_len_i) |=> flt_len_o);
endmodule

bind avr_xlate_check avr_xlate_check_sva #(.PFN_W(PFN_W)) u_sva (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .va_i       (va_i),
  .wr_i       (wr_i),
  .mode_i     (mode_i),
  .rgn0_len_i (rgn0_len_i),
  .prot_i     (prot_i),
  .pfn_i      (pfn_i),
  .pa_o       (pa_o),
  .pa_valid_o (pa_valid_o),
  .flt_len_o  (flt_len_o),
  .flt_acc_o  (flt_acc_o),
  .flt_rsv_o  (flt_rsv_o)
);

// File: tb/tb_avr_xlate_check.sv
`timescale 1ns/1ps
module tb_avr_xlate_check;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [31:0] va_i = '0;
  logic        wr_i = 1'b0;
  logic [1:0]  mode_i = '0;
  logic [21:0] rgn0_len_i = '0, rgn1_len_i = '0, rgn2_len_i = '0;
  logic [3:0]  prot_i = '0;
  logic [20:0] pfn_i = '0;
  logic [29:0] pa_o;
  logic        pa_valid_o, flt_len_o, flt_acc_o, flt_rsv_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [29:0] e_pa;
  logic        e_val, e_len, e_acc, e_rsv;
  string       e_tag;

  always #4 clk_i = ~clk_i;

  avr_xlate_check dut (.*);

  task automatic check_now();
    checks++;
    if (pa_o !== e_pa || pa_valid_o !== e_val || flt_len_o !== e_len ||
        flt_acc_o !== e_acc || flt_rsv_o !== e_rsv) begin
      fails++;
      $display("FAIL %s: got pa=%h v=%b len=%b acc=%b rsv=%b exp pa=%h v=%b len=%b acc=%b rsv=%b",
               e_tag, pa_o, pa_valid_o, flt_len_o, flt_acc_o, flt_rsv_o,
               e_pa, e_val, e_len, e_acc, e_rsv);
    end
  endtask

  // behavioural reference, evaluated on the inputs applied this cycle
  task automatic model(input string force_tag);
    int rgn, vpn, lim, rd_l, wr_l, need;
    bit lf, af;
    e_pa = '0; e_val = 0; e_len = 0; e_acc = 0; e_rsv = 0;
    if (!req_i) begin e_tag = "R9"; return; end
    rgn = int'(va_i[31:30]);
    vpn = int'(va_i[29:9]);
    if (rgn == 3) begin e_rsv = 1; e_tag = "R1"; end
    else begin
      lim = (rgn == 0) ? int'(rgn0_len_i) : (rgn == 1) ? int'(rgn1_len_i) : int'(rgn2_len_i);
      lf  = (rgn == 1) ? (vpn < lim) : (vpn >= lim);
      rd_l = int'(prot_i[1:0]);
      wr_l = int'(prot_i[3:2]);
      need = wr_i ? wr_l : rd_l;
      af = (wr_l > rd_l) || (int'(mode_i) > need);
      if (lf) begin e_len = 1; e_tag = (rgn == 1) ? "R3" : "R2"; end
      else if (af) begin
        e_acc = 1;
        e_tag = (wr_l > rd_l) ? "R6" : (wr_i ? "R5" : "R4");
      end else begin
        e_val = 1; e_pa = {pfn_i, va_i[8:0]}; e_tag = "R8";
      end
    end
    if (force_tag != "") e_tag = force_tag;
  endtask

  task automatic step(input bit rq, input int rgn, input int vpn, input bit wr,
                      input int mode, input int prot, input string tag);
    @(negedge clk_i);
    check_now();
    req_i  = rq;
    va_i   = {rgn[1:0], vpn[20:0], 9'($urandom_range(0, 511))};
    wr_i   = wr;
    mode_i = mode[1:0];
    prot_i = prot[3:0];
    pfn_i  = 21'($urandom);
    model(tag);
  endtask

  initial begin
    e_pa = '0; e_val = 0; e_len = 0; e_acc = 0; e_rsv = 0; e_tag = "R10";
    repeat (3) @(negedge clk_i);
    check_now();                    // R10 reset state
    rgn0_len_i = 22'd100;
    rgn1_len_i = 22'h1FFF00;
    rgn2_len_i = 22'd50;
    @(negedge clk_i);
    rst_ni = 1'b1;
    check_now();                    // R10 still idle after release
    // R2 region 0 and 2 boundaries
    step(1, 0, 99, 0, 0, 0, "");
    step(1, 0, 100, 0, 0, 0, "R2");
    step(1, 2, 49, 1, 0, 0, "");
    step(1, 2, 50, 1, 0, 0, "R2");
    // R3 region 1 grows down
    step(1, 1, 'h1FFF00, 0, 0, 0, "R3");
    step(1, 1, 'h1FFEFF, 0, 0, 0, "R3");
    step(1, 1, 'h1FFFFF, 1, 0, 0, "R3");
    // R1 reserved region
    step(1, 3, 5, 0, 0, 'hF, "R1");
    step(1, 3, 0, 1, 3, 0, "R1");
    // R4 / R5 split levels
    step(1, 0, 7, 0, 3, 'b0011, "R4");
    step(1, 0, 7, 1, 3, 'b0011, "R5");
    step(1, 0, 7, 1, 0, 'b0011, "R5");
    step(1, 0, 7, 1, 2, 'b1010, "R5");
    step(1, 0, 7, 1, 3, 'b1010, "R5");
    step(1, 0, 7, 0, 1, 'b1010, "R4");
    step(1, 0, 7, 0, 2, 'b0001, "R4");
    // R6 invalid code
    step(1, 0, 7, 0, 0, 'b1101, "R6");
    step(1, 2, 3, 1, 0, 'b1100, "R6");
    // R7 length outranks protection, reserved outranks all
    step(1, 0, 200, 1, 3, 'b1101, "R7");
    step(1, 1, 0, 1, 3, 0, "R7");
    step(1, 3, 200, 1, 3, 'b1101, "R7");
    // R9 idle after a valid result
    step(1, 0, 1, 0, 0, 0, "R8");
    step(0, 0, 1, 0, 0, 0, "R9");
    step(0, 3, 1, 1, 3, 0, "R9");
    // mixed traffic
    for (int i = 0; i < 4000; i++) begin
      int r, v;
      r = $urandom_range(0, 3);
      if (r == 1) v = 'h1FFF00 + $urandom_range(0, 255) - 128;
      else if (r == 0) v = $urandom_range(0, 200);
      else v = $urandom_range(0, 100);
      step($urandom_range(0, 7) != 0, r, v, 1'($urandom), $urandom_range(0, 3),
           $urandom_range(0, 15), "");
    end
    @(negedge clk_i);
    check_now();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule